// File: doc/BRIEF.md
# Serial Configuration Daisy-Chain Shifter

This block is the serial front end of a device that loads its setup from a bit stream shared by several devices wired in a chain. Each rising edge of the configuration clock takes one bit from the serial input. As long as the device still needs bits for itself, those bits are packed into a word of parameterized width, most significant bit first. Each finished word is announced with a single-cycle valid strobe.

Once the controller upstream says that this device's own frame is complete, the block stops packing. It relays every bit it takes in to the pass-through output, which feeds the serial input of the next device in the chain. The relayed bit leaves on a falling clock edge, one and a half clock periods after the rising edge that captured it. When nothing is being relayed, the pass-through output sits at logic high.

The relay path uses two rising-edge stages followed by one falling-edge register. Each captured bit travels with the frame-complete flag that was present when it was captured. A change of that flag therefore takes effect on exactly the bit that was sampled with it, in both the packing path and the relay path.

Top module: `cfg_chain_shifter`

## Requirements
- R1: While reset is asserted (rst_n low), dout is 1, word_valid is 0 and word is all zeros.
- R2: When frame_done is 0 at a rising clock edge, din is captured at that edge into the word under assembly. The first captured bit of a word ends up in bit WORD_W-1 of word, and the last one in bit 0.
- R3: After the rising edge that captures the WORD_W-th own bit, word_valid is 1 for exactly one clock cycle, and word carries the completed value during that cycle.
- R4: A bit captured while frame_done is 1 does not enter the word. A partly filled word keeps its bits through such an interval and continues with the next own bit.
- R5: A bit captured at rising edge k with frame_done at 1 appears on dout at the falling edge that follows rising edge k+1, which is 1.5 clock periods after capture.
- R6: At the falling edge that follows rising edge k+1, dout becomes 1 when the bit captured at rising edge k had frame_done at 0.
- R7: dout changes only at falling clock edges. Between a falling edge and the next falling edge, including across the rising edge in between, it holds its value.
- R8: An asynchronous reset during a partial word discards the partial word. The first WORD_W own bits after reset form a fresh word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; rising edge samples, falling edge drives dout |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Serial configuration data in |
| frame_done | input | 1 | 1 = this device's frame is complete, so relay din downstream |
| dout | output | 1 | Serial pass-through to the next device; idles high |
| word | output | WORD_W | Last assembled configuration word |
| word_valid | output | 1 | One-cycle strobe marking a new word |

## Verification
Two events can fall in the same cycle: the completion pulse of a word, and the capture of the first bit to be relayed. This happens when frame_done rises at the edge right after the last own bit. The bench provokes it deliberately, and also through long runs in which frame_done toggles at random in the middle of words. A scoreboard model predicts each packed word and each dout value independently, and compares the pulse, the word and the relayed bit in their separate cycles. Neither event may suppress or delay the other, and a bit captured under one flag value must never leak into the other path.

// File: rtl/cfgchain_pkg.sv
package cfgchain_pkg;

    // One captured serial bit together with the relay decision made for it.
    typedef struct packed {
        logic data;
        logic relay;
    } chain_bit_t;

    localparam chain_bit_t CHAIN_BIT_IDLE = '{data: 1'b0, relay: 1'b0};

endpackage

// File: rtl/cfg_sample_pipe.sv
module cfg_sample_pipe
    import cfgchain_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       din,
    input  logic       relay_en,
    output chain_bit_t late_o
);

    typedef struct packed {
        chain_bit_t stage1;
        chain_bit_t stage2;
    } pipe_t;

    pipe_t st_d, st_q;

    always_comb begin
        st_d             = st_q;
        st_d.stage1.data  = din;
        st_d.stage1.relay = relay_en;
        st_d.stage2       = st_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stage1 <= CHAIN_BIT_IDLE;
            st_q.stage2 <= CHAIN_BIT_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign late_o = st_q.stage2;

endmodule

// File: rtl/cfg_fwd_out.sv
module cfg_fwd_out
    import cfgchain_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  chain_bit_t late_i,
    output logic       dout
);

    logic dout_d, dout_q;

    always_comb begin
        dout_d = late_i.relay ? late_i.data : 1'b1;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= 1'b1;
        end else begin
            dout_q <= dout_d;
        end
    end

    assign dout = dout_q;

endmodule

// File: rtl/cfg_word_asm.sv
module cfg_word_asm #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic              relay_en,
    output logic [WORD_W-1:0] word,
    output logic              word_valid
);

    localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-2:0] partial;
        logic [CNT_W-1:0]  fill;
        logic [WORD_W-1:0] word;
        logic              vld;
    } asm_t;

    asm_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (!relay_en) begin
            st_d.partial = {st_q.partial[WORD_W-3:0], din};
            if (st_q.fill == LAST_IDX) begin
                st_d.word = {st_q.partial, din};
                st_d.vld  = 1'b1;
                st_d.fill = '0;
            end else begin
                st_d.fill = st_q.fill + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word       = st_q.word;
    assign word_valid = st_q.vld;

endmodule

// File: rtl/cfg_chain_shifter.sv
module cfg_chain_shifter
    import cfgchain_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic              frame_done,
    output logic              dout,
    output logic [WORD_W-1:0] word,
    output logic              word_valid
);

    chain_bit_t late_bit;

    cfg_sample_pipe u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .relay_en (frame_done),
        .late_o   (late_bit)
    );

    cfg_fwd_out u_fwd (
        .clk    (clk),
        .rst_n  (rst_n),
        .late_i (late_bit),
        .dout   (dout)
    );

    cfg_word_asm #(.WORD_W(WORD_W)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (din),
        .relay_en   (frame_done),
        .word       (word),
        .word_valid (word_valid)
    );

endmodule

// File: rtl/cfg_chain_shifter_chk.sv
module cfg_chain_shifter_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              din,
    input logic              frame_done,
    input logic              dout,
    input logic [WORD_W-1:0] word,
    input logic              word_valid
);

    // Rising edges seen since reset was released, saturating at 2.
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd2) begin
            age_q <= age_q + 2'd1;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |-> (dout && !word_valid && word == '0));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    a_r4_no_pack_when_relaying: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !word_valid);

    a_r5_relay_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && $past(frame_done, 2)) |-> (dout == $past(din, 2)));

    a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && !$past(frame_done, 2)) |-> dout);

endmodule

bind cfg_chain_shifter cfg_chain_shifter_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .din        (din),
    .frame_done (frame_done),
    .dout       (dout),
    .word       (word),
    .word_valid (word_valid)
);

// File: tb/tb_cfg_chain_shifter.sv
`timescale 1ns/1ps
module tb_cfg_chain_shifter;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic         din = 1'b0;
    logic         frame_done = 1'b0;
    logic         dout;
    logic [W-1:0] word;
    logic         word_valid;

    cfg_chain_shifter #(.WORD_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .din(din), .frame_done(frame_done),
        .dout(dout), .word(word), .word_valid(word_valid)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int   due;
        logic val;
    } exp_bit_t;

    exp_bit_t     dq[$];
    logic [W-1:0] wq[$];
    logic [W-1:0] m_shift = '0;
    int           m_fill = 0;
    int           cyc = 0;
    int           n_tests = 0;
    int           n_fail = 0;
    logic         last_exp = 1'b1;
    bit           have_last = 1'b0;
    bit           done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: presents one bit, predicts the relay output and any word it completes.
    task automatic send(input logic b, input logic fd);
        @(posedge clk);
        #1;
        din = b;
        frame_done = fd;
        dq.push_back('{due: cyc + 2, val: (fd ? b : 1'b1)});
        if (!fd) begin
            m_shift = {m_shift[W-2:0], b};
            m_fill++;
            if (m_fill == W) begin
                wq.push_back(m_shift);
                m_fill = 0;
            end
        end
    endtask

    task automatic send_word(input logic [W-1:0] v);
        for (int i = W - 1; i >= 0; i--) send(v[i], 1'b0);
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        #0.5;
        check(dout == 1'b1, "R1", "dout in reset", int'(dout), 1);
        check(word_valid == 1'b0, "R1", "word_valid in reset", int'(word_valid), 0);
        check(word == '0, "R1", "word in reset", int'(word), 0);
        dq.delete();
        wq.delete();
        m_shift = '0;
        m_fill = 0;
        have_last = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        din = 1'b0;
        frame_done = 1'b1;
        dq.push_back('{due: cyc + 2, val: 1'b0});
    endtask

    // Monitor for the falling-edge relay output (R5, R6).
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            while (dq.size() > 0 && dq[0].due < cyc) begin
                check(1'b0, "R5", "relay item missed", dq[0].due, cyc);
                void'(dq.pop_front());
            end
            if (dq.size() > 0 && dq[0].due == cyc) begin
                check(dout === dq[0].val, "R5", "dout after 1.5 periods",
                      int'(dout), int'(dq[0].val));
                last_exp = dq[0].val;
                have_last = 1'b1;
                void'(dq.pop_front());
            end
        end
    end

    // Monitor for words (R2, R3, R4) and for dout holding across rising edges (R7).
    always @(posedge clk) begin
        #1.5;
        if (rst_n) begin
            if (word_valid) begin
                if (wq.size() == 0) begin
                    check(1'b0, "R4", "unexpected word pulse", int'(word), 0);
                end else begin
                    check(word === wq[0], "R2", "assembled word", int'(word), int'(wq[0]));
                    void'(wq.pop_front());
                end
            end
            if (have_last) begin
                check(dout === last_exp, "R7", "dout across rising edge",
                      int'(dout), int'(last_exp));
            end
        end
    end

    initial begin
        #1;
        rst_n = 1'b0;
        #0.5;
        check(dout == 1'b1, "R1", "dout at start", int'(dout), 1);
        check(word_valid == 1'b0, "R1", "word_valid at start", int'(word_valid), 0);
        check(word == '0, "R1", "word at start", int'(word), 0);
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        frame_done = 1'b0;
        din = 1'b0;
        // The idle bit sampled right after release is an own bit: model it.
        m_shift = {m_shift[W-2:0], 1'b0};
        m_fill = 1;
        dq.push_back('{due: cyc + 2, val: 1'b1});
        for (int i = 1; i < W; i++) send(1'b0, 1'b0);

        // R2: MSB-first packing of distinct patterns.
        send_word(8'hA5);
        send_word(8'h3C);
        send_word(8'hFF);
        send_word(8'h01);

        // R5: relay a pattern downstream.
        send(1'b1, 1'b1); send(1'b0, 1'b1); send(1'b1, 1'b1); send(1'b1, 1'b1);
        send(1'b0, 1'b1); send(1'b0, 1'b1); send(1'b1, 1'b1); send(1'b0, 1'b1);

        // R4: partial word held across a relay interval.
        send(1'b1, 1'b0); send(1'b1, 1'b0); send(1'b0, 1'b0);
        send(1'b0, 1'b1); send(1'b1, 1'b1); send(1'b0, 1'b1); send(1'b1, 1'b1);
        send(1'b1, 1'b0); send(1'b0, 1'b0); send(1'b1, 1'b0); send(1'b0, 1'b0); send(1'b1, 1'b0);

        // R3 with R5: word completion and first relayed bit in adjacent captures.
        send_word(8'h5A);
        send(1'b0, 1'b1); send(1'b1, 1'b1); send(1'b0, 1'b1);

        // R6: own bits keep dout high.
        send_word(8'h00);

        // Random mix of own and relayed bits.
        for (int i = 0; i < 400; i++) send(1'($urandom), 1'($urandom));

        // R8: reset in the middle of a word, then a fresh word.
        send(1'b1, 1'b0); send(1'b1, 1'b0); send(1'b1, 1'b0);
        do_reset();
        send_word(8'hC3);
        send_word(8'h96);

        for (int i = 0; i < 4; i++) send(1'b1, 1'b1);
        repeat (4) @(posedge clk);
        #2;
        check(dq.size() == 0, "R5", "relay items left", dq.size(), 0);
        check(wq.size() == 0, "R3", "words left", wq.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule